// File: doc/BRIEF.md
# Keyed Reset and Priority-Grouping Control Register

This block is a single 32-bit control register on a simple register bus. The bus has an address, a write strobe, write data and combinational read data. The register holds a 3-bit priority-grouping selector and reports the byte order of the system in a read-only bit. Through the same register, software can ask for a whole-system reset or a local core reset. Each request is driven out as a one-cycle pulse toward reset sequencing logic outside this block.

Every write is guarded by a 16-bit unlock key in the upper half of the write data. A write without the key changes nothing.

Next to the register, a combinational splitter takes a stored interrupt priority value of `PRIO_BITS` bits. Using the current grouping, it divides that value into a preemption part and a sub-priority part. Interrupt arbitration logic elsewhere uses this split to decide which requests may preempt others.

Top module: `keyed_grp_ctl`

## Requirements
- R1: After reset, the grouping field is 0, both request outputs are low, and a read returns zero in bits [10:8].
- R2: A write strobe at the register address with bits [31:16] equal to 0x05FA loads bits [10:8] of the write data into the grouping field. The new value is visible on reads from the next cycle.
- R3: A write whose bits [31:16] differ from 0x05FA changes nothing. The grouping field is unchanged and no request pulse is produced.
- R4: A keyed write with bit 2 set drives `sys_reset_req` high for exactly the one cycle after the write edge.
- R5: A keyed write with bit 0 set drives `core_reset_req` high for exactly the one cycle after the write edge.
- R6: Reads return `RD_UPPER` (default 0x0000) in bits [31:16]. Bits 2 and 0 always read as 0. Every bit other than 15 and [10:8] reads 0.
- R7: Bit 15 reads the endianness indication, taken from `big_endian` in the default variant. A write with bit 15 set does not change it.
- R8: A keyed reset-request write also loads bits [10:8]. A request that carries the current grouping value therefore leaves the grouping unchanged.
- R9: With N = `PRIO_BITS` and grouping g, the preemption width is min(N, 7-g). The sub-priority width is 0 when g+N < 7 and g+N-7 otherwise.
- R10: `preempt_part` equals `prio_value` shifted right by the sub width and masked to the preemption width. `sub_part` equals `prio_value` masked to the sub width.
- R11: A write strobe to any address other than `REG_ADDR` changes nothing, even when it carries the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| big_endian | input | 1 | Byte-order indication shown in bit 15 |
| prio_value | input | PRIO_BITS | Stored priority value to split |
| grp_sel | output | 3 | Current grouping field |
| preempt_part | output | PRIO_BITS | Preemption part of `prio_value` |
| sub_part | output | PRIO_BITS | Sub-priority part of `prio_value` |
| sys_reset_req | output | 1 | One-cycle system reset request |
| core_reset_req | output | 1 | One-cycle local core reset request |

## Verification
A wrong grouping state shows up on the read data and on `grp_sel` on the first cycle after the write edge. It shows up in the same cycle on the priority split, so each decode check also covers the stored field. A faulty key comparison shows as a grouping change or a request pulse after an unkeyed write, and that too is visible on the next cycle. A request line that stays high, or that rises on the wrong write, is caught by sampling the line in the cycle after the write and again in the cycle after that.

// File: rtl/keyed_grp_pkg.sv
package keyed_grp_pkg;
   // Unlock key expected in bits [31:16] of a write
   localparam logic [15:0] UNLOCK_KEY = 16'h05FA;
   // Field positions that software and reset logic depend on
   localparam int GRP_LSB   = 8;
   localparam int GRP_W     = 3;
   localparam int SYS_BIT   = 2;
   localparam int CORE_BIT  = 0;
   localparam int ENDIAN_BIT = 15;
   localparam int NUM_REQ   = 2;

   typedef struct packed {
      logic [GRP_W-1:0] grp;
      logic             sys_req;
      logic             core_req;
   } ctl_fields_t;

   function automatic ctl_fields_t unpack_wdata(input logic [31:0] d);
      ctl_fields_t f;
      f.grp      = d[GRP_LSB +: GRP_W];
      f.sys_req  = d[SYS_BIT];
      f.core_req = d[CORE_BIT];
      return f;
   endfunction
endpackage

// File: rtl/keyed_grp_store.sv
module keyed_grp_store
   import keyed_grp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             bus_wr,
   input  logic [31:0]      bus_wdata,
   output logic             accept,
   output ctl_fields_t      fields,
   output logic [GRP_W-1:0] grp_q
);
   logic key_ok;

   assign key_ok = (bus_wdata[31:16] == UNLOCK_KEY);
   assign accept = bus_wr & hit & key_ok;
   assign fields = unpack_wdata(bus_wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         grp_q <= '0;
      else if (accept)
         grp_q <= fields.grp;
   end

   // Unkeyed writes leave the grouping untouched
   assert_unkeyed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && bus_wdata[31:16] != UNLOCK_KEY) |=> $stable(grp_q));

   // Writes elsewhere leave the grouping untouched
   assert_other_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit) |=> $stable(grp_q));
endmodule

// File: rtl/keyed_req_pulse.sv
module keyed_req_pulse #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           accept,
   input  logic [NUM-1:0] req_bits,
   output logic [NUM-1:0] req_q
);
   initial begin
      if (NUM < 1) $error("keyed_req_pulse: NUM must be at least 1");
   end

   for (genvar i = 0; i < NUM; i++) begin : g_req
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            req_q[i] <= 1'b0;
         else
            req_q[i] <= accept & req_bits[i];
      end

      // A request is only ever seen right after an accepted write that set it (R4, R5)
      assert_req_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
         req_q[i] |-> $past(accept && req_bits[i]));
   end
endmodule

// File: rtl/keyed_prio_split.sv
module keyed_prio_split #(
   parameter int PRIO_BITS = 4
) (
   input  logic [2:0]           grp,
   input  logic [PRIO_BITS-1:0] prio,
   output logic [PRIO_BITS-1:0] preempt,
   output logic [PRIO_BITS-1:0] sub
);
   localparam int SHW = $clog2(PRIO_BITS + 1);

   int unsigned pre_w;
   int unsigned sub_w;
   logic [PRIO_BITS:0] pre_mask;
   logic [PRIO_BITS:0] sub_mask;

   always_comb begin
      pre_w = ((7 - int'(grp)) > PRIO_BITS) ? PRIO_BITS : (7 - int'(grp));
      sub_w = ((int'(grp) + PRIO_BITS) < 7) ? 0 : (int'(grp) + PRIO_BITS - 7);
      pre_mask = ({{PRIO_BITS{1'b0}}, 1'b1} << pre_w[SHW-1:0]) - 1'b1;
      sub_mask = ({{PRIO_BITS{1'b0}}, 1'b1} << sub_w[SHW-1:0]) - 1'b1;
      preempt = (prio >> sub_w[SHW-1:0]) & pre_mask[PRIO_BITS-1:0];
      sub     = prio & sub_mask[PRIO_BITS-1:0];
   end

   // The two parts together cover the implemented bits
   always_comb begin
      assert_width_sum_R9: assert (pre_w + sub_w == PRIO_BITS);
   end
   // The two parts reassemble into the input value
   always_comb begin
      assert_rebuild_R10: assert (((preempt << sub_w[SHW-1:0]) | sub) == prio);
   end
endmodule

// File: rtl/keyed_grp_ctl.sv
module keyed_grp_ctl
   import keyed_grp_pkg::*;
#(
   parameter int          ADDR_W     = 4,
   parameter int          REG_ADDR   = 3,
   parameter int          PRIO_BITS  = 4,
   parameter logic [15:0] RD_UPPER   = 16'h0000,
   parameter bit          ENDIAN_PIN = 1'b1,
   parameter bit          ENDIAN_FIX = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic                 big_endian,
   input  logic [PRIO_BITS-1:0] prio_value,
   output logic [2:0]           grp_sel,
   output logic [PRIO_BITS-1:0] preempt_part,
   output logic [PRIO_BITS-1:0] sub_part,
   output logic                 sys_reset_req,
   output logic                 core_reset_req
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

   initial begin
      if (PRIO_BITS < 1 || PRIO_BITS > 8) $error("PRIO_BITS out of range 1..8");
      if (REG_ADDR >= (1 << ADDR_W)) $error("REG_ADDR does not fit ADDR_W");
   end

   logic             hit;
   logic             accept;
   ctl_fields_t      fields;
   logic [GRP_W-1:0] grp_q;
   logic [NUM_REQ-1:0] req_q;
   logic             endian_bit;

   assign hit = (bus_addr == MY_ADDR);

   keyed_grp_store u_store (
      .clk(clk), .rst_n(rst_n), .hit(hit), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .accept(accept), .fields(fields), .grp_q(grp_q)
   );

   keyed_req_pulse #(.NUM(NUM_REQ)) u_pulse (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .req_bits({fields.sys_req, fields.core_req}), .req_q(req_q)
   );

   keyed_prio_split #(.PRIO_BITS(PRIO_BITS)) u_split (
      .grp(grp_q), .prio(prio_value), .preempt(preempt_part), .sub(sub_part)
   );

   if (ENDIAN_PIN) begin : g_endian_pin
      assign endian_bit = big_endian;
   end else begin : g_endian_fix
      logic unused_pin;
      assign unused_pin = big_endian;
      assign endian_bit = ENDIAN_FIX;
   end

   assign sys_reset_req  = req_q[1];
   assign core_reset_req = req_q[0];
   assign grp_sel        = grp_q;

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         bus_rdata[31:16]              = RD_UPPER;
         bus_rdata[ENDIAN_BIT]         = endian_bit;
         bus_rdata[GRP_LSB +: GRP_W]   = grp_q;
      end
   end

   // A core reset pulse only follows a keyed write with bit 0 set
   assert_core_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      core_reset_req |-> $past(bus_wr && hit && bus_wdata[31:16] == UNLOCK_KEY && bus_wdata[CORE_BIT]));
   // A system reset pulse is never longer than one cycle without a fresh request
   assert_sys_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_reset_req && !$past(bus_wr)) |=> !sys_reset_req);
   // A keyed write sets the grouping to the written field
   assert_keyed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit && bus_wdata[31:16] == UNLOCK_KEY) |=> (grp_sel == $past(bus_wdata[10:8])));
endmodule

// File: tb/keyed_grp_ctl_test.sv
module keyed_grp_ctl_test;
   localparam int N = 4;
   localparam logic [3:0] RA = 4'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] bus_addr = RA;
   logic bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic big_endian = 1'b0;
   logic [N-1:0] prio_value = '0;
   logic [2:0] grp_sel;
   logic [N-1:0] preempt_part, sub_part;
   logic sys_reset_req, core_reset_req;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   keyed_grp_ctl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .big_endian(big_endian),
      .prio_value(prio_value), .grp_sel(grp_sel), .preempt_part(preempt_part),
      .sub_part(sub_part), .sys_reset_req(sys_reset_req), .core_reset_req(core_reset_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one write; returns at the falling edge right after the write edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = RA; bus_wdata = '0;
   endtask

   function automatic logic [31:0] keyed(input logic [2:0] g, input bit sys, input bit core);
      return {16'h05FA, 5'b0, g, 5'b0, sys, 1'b0, core};
   endfunction

   task automatic t_reset();
      #1;
      check("R1 grp", {29'b0, grp_sel}, 32'd0);
      check("R1 rdata grp", {29'b0, bus_rdata[10:8]}, 32'd0);
      check("R1 reqs", {30'b0, sys_reset_req, core_reset_req}, 32'd0);
   endtask

   task automatic t_keyed_write();
      wr(RA, keyed(3'd5, 0, 0));
      check("R2 grp", {29'b0, grp_sel}, 32'd5);
      check("R2 rdata", bus_rdata, 32'h0000_0500);
      wr(RA, keyed(3'd2, 0, 0));
      check("R2 rdata second", bus_rdata, 32'h0000_0200);
   endtask

   task automatic t_bad_key();
      wr(RA, 32'h05FB_0705);
      check("R3 grp", {29'b0, grp_sel}, 32'd2);
      check("R3 no pulse", {30'b0, sys_reset_req, core_reset_req}, 32'd0);
      wr(RA, 32'h0000_0600);
      check("R3 zero key", bus_rdata, 32'h0000_0200);
   endtask

   task automatic t_sys_pulse();
      wr(RA, keyed(3'd2, 1, 0));
      check("R4 sys high", {31'b0, sys_reset_req}, 32'd1);
      check("R4 core low", {31'b0, core_reset_req}, 32'd0);
      check("R8 grp kept", {29'b0, grp_sel}, 32'd2);
      check("R6 bit2 reads 0", {31'b0, bus_rdata[2]}, 32'd0);
      @(negedge clk);
      check("R4 sys dropped", {31'b0, sys_reset_req}, 32'd0);
   endtask

   task automatic t_core_pulse();
      wr(RA, keyed(3'd6, 0, 1));
      check("R5 core high", {31'b0, core_reset_req}, 32'd1);
      check("R5 sys low", {31'b0, sys_reset_req}, 32'd0);
      check("R8 grp from request", {29'b0, grp_sel}, 32'd6);
      check("R6 bit0 reads 0", {31'b0, bus_rdata[0]}, 32'd0);
      @(negedge clk);
      check("R5 core dropped", {31'b0, core_reset_req}, 32'd0);
   endtask

   task automatic t_readback();
      wr(RA, 32'h05FA_FFFF);
      check("R6 rdata mask", bus_rdata, 32'h0000_0700);
      @(negedge clk);
   endtask

   task automatic t_endian();
      big_endian = 1'b1;
      #1 check("R7 endian 1", {31'b0, bus_rdata[15]}, 32'd1);
      big_endian = 1'b0;
      wr(RA, 32'h05FA_8300);
      check("R7 write ignored", {31'b0, bus_rdata[15]}, 32'd0);
   endtask

   task automatic t_other_addr();
      wr(4'd4, keyed(3'd1, 1, 1));
      check("R11 grp", {29'b0, grp_sel}, 32'd3);
      check("R11 no pulse", {30'b0, sys_reset_req, core_reset_req}, 32'd0);
   endtask

   task automatic t_split();
      for (int g = 0; g < 8; g++) begin
         int pw, sw;
         wr(RA, keyed(3'(g), 0, 0));
         pw = ((7 - g) > N) ? N : 7 - g;
         sw = ((g + N) < 7) ? 0 : g + N - 7;
         check("R9 widths", pw + sw, N);
         for (int p = 0; p < (1 << N); p += 3) begin
            int ep, es;
            prio_value = N'(p);
            ep = (p >> sw) & ((1 << pw) - 1);
            es = p & ((1 << sw) - 1);
            #1;
            check("R10 preempt", {28'b0, preempt_part}, 32'(ep));
            check("R10 sub", {28'b0, sub_part}, 32'(es));
         end
      end
   endtask

   initial begin
      #2000000;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_keyed_write();
      t_bad_key();
      t_sys_pulse();
      t_core_pulse();
      t_readback();
      t_endian();
      t_other_addr();
      t_split();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule